// File: doc/BRIEF.md
# PCIe Link Watch and Speed-Change Recovery

This block supervises link bring-up for a PCIe controller. After a start strobe it samples the controller's two 32-bit debug status words on a fixed tick-based polling schedule. It reports the link as up once the "link up" flag is set and the "in training" flag is clear in the same poll. If no such poll arrives before a deadline, it raises a timeout and goes back to idle.

While it waits, the block also watches for a speed change that has stalled. Once a settle interval has passed since the start, a poll may find the LTSSM parked in the receiver-lock recovery state. In that case the block asks the PHY, through a register-access request/response port, whether the receiver sees valid data. If the receiver reports data invalid, the block briefly forces the receiver's data-enable and PLL-enable override bits on and then clears them again. Each change is a read-modify-write of the PHY override register. A one-cycle event flags every completed pulse.

Time is measured in ticks from an external strobe, normally one per millisecond. The polling period, the settle interval and the deadline are tick counts given as parameters.

Top module: `pcie_link_watch`

## Requirements
- R1: While `rst` is high and after it falls, `link_up`, `timeout`, `recov_evt` and `phy_req` are all 0 until a start is accepted.
- R2: At each poll, `link_up` becomes 1 if and only if bit 4 of `dbg_word1` is 1 and bit 29 of `dbg_word1` is 0. Once set, it stays 1 whatever the debug words do, until the next `start` or `rst`.
- R3: Polls happen every `POLL_TICKS` ticks of `ms_tick`, counted from the accepted `start`. A `start` is accepted only in idle or after link up.
- R4: If `DEADLINE_TICKS` ticks elapse without a poll that sees the link up, `timeout` rises and the block returns to idle. `timeout` stays 1 until the next accepted `start` clears it. `link_up` and `timeout` are never 1 together.
- R5: A PHY access is started only from a poll where `dbg_word0[5:0]` equals `RCVRLOCK_CODE` (default 6'h0D) and at least `SETTLE_TICKS` ticks have elapsed since start. Otherwise `phy_req` stays 0.
- R6: The stall probe is a read (`phy_we`=0) of PHY address 16'h100D. Bit 0 of the returned data is the receiver-valid flag. If it is 1, no override access follows and polling resumes.
- R7: If the receiver-valid flag is 0, the block performs four accesses in this order, all at 16'h1005: a read; a write of the read value OR 16'h0028 (bit 5 data enable, bit 3 PLL enable); a second read; and a write of that value AND NOT 16'h0028.
- R8: `recov_evt` pulses high for exactly one clock after the final override write of each sequence is acknowledged. Polling then resumes.
- R9: Once raised, `phy_req` stays high with `phy_we`, `phy_addr` and `phy_wdata` stable until a cycle with `phy_ack` high. `phy_rdata` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) link supervision |
| ms_tick | input | 1 | One-cycle time-base strobe |
| dbg_word0 | input | 32 | Debug status word 0; [5:0] is the LTSSM state |
| dbg_word1 | input | 32 | Debug status word 1; bit 4 up, bit 29 in training |
| phy_req | output | 1 | PHY access request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY access completion, one cycle |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |
| link_up | output | 1 | Link declared up |
| timeout | output | 1 | Deadline expired without link |
| recov_evt | output | 1 | One-cycle pulse per completed override pulse |

## Verification
The bench sweeps all four combinations of the up and in-training flags over several background patterns. A design that ignores the training flag or tests the wrong bit reports the link up falsely, or reports a timeout when the link is up. The tick count at which `link_up` or `timeout` rises is checked against the poll period and the deadline, so a miscounted period or an off-by-one deadline shows up as a wrong tick. The override sequence is logged through a PHY model that answers late, and each access is compared for order, address and data. A missing bit in the override mask, reversed set and clear steps, or a probe sent before the settle interval or in the wrong LTSSM state each show up as a mismatched log entry or an unexpected access.

// File: rtl/plw_pkg.sv
package plw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CHECK,
        ST_PROBE,
        ST_OVR_RD1,
        ST_OVR_WR1,
        ST_OVR_RD2,
        ST_OVR_WR2,
        ST_UP
    } plw_state_e;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
    } phy_op_t;

    localparam logic [15:0] RXSTAT_ADDR = 16'h100D;
    localparam logic [15:0] OVRD_ADDR   = 16'h1005;
    localparam logic [15:0] OVRD_MASK   = 16'h0028;

    function automatic logic link_ok(input logic [31:0] w);
        return w[4] & ~w[29];
    endfunction

    function automatic phy_op_t mk_op(input logic we, input logic [15:0] a,
                                      input logic [15:0] d);
        phy_op_t o;
        o.we   = we;
        o.addr = a;
        o.data = d;
        return o;
    endfunction

endpackage

// File: rtl/plw_tick_cnt.sv
module plw_tick_cnt #(
    parameter int LIMIT = 4,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          reached
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    assign reached = (count >= LIM);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick && !reached) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/plw_phy_port.sv
module plw_phy_port
    import plw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  phy_op_t       op,
    input  logic          phy_ack,
    input  logic [15:0]   phy_rdata,
    output logic          phy_req,
    output logic          phy_we,
    output logic [15:0]   phy_addr,
    output logic [15:0]   phy_wdata,
    output logic          done,
    output logic [15:0]   rdata
);
    phy_op_t cur;

    assign phy_we    = cur.we;
    assign phy_addr  = cur.addr;
    assign phy_wdata = cur.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_req <= 1'b0;
            done    <= 1'b0;
            cur     <= '0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !phy_req) begin
                cur     <= op;
                phy_req <= 1'b1;
            end else if (phy_req && phy_ack) begin
                phy_req <= 1'b0;
                done    <= 1'b1;
                rdata   <= phy_rdata;
            end
        end
    end
endmodule

// File: rtl/pcie_link_watch.sv
module pcie_link_watch
    import plw_pkg::*;
#(
    parameter int         POLL_TICKS     = 1,
    parameter int         SETTLE_TICKS   = 2,
    parameter int         DEADLINE_TICKS = 100,
    parameter logic [5:0] RCVRLOCK_CODE  = 6'h0D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ms_tick,
    input  logic [31:0] dbg_word0,
    input  logic [31:0] dbg_word1,
    output logic        phy_req,
    output logic        phy_we,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        link_up,
    output logic        timeout,
    output logic        recov_evt
);
    localparam int ECW = $clog2(DEADLINE_TICKS + 1);
    localparam int PCW = $clog2(POLL_TICKS + 1);

    plw_state_e   state;
    logic         go;
    phy_op_t      op;
    logic         done;
    logic [15:0]  rd_val;
    logic         running;
    logic         accept;
    logic [ECW-1:0] elapsed;
    logic         deadline_hit;
    logic [PCW-1:0] poll_cnt;
    logic         poll_hit;
    logic         settled;
    logic         stall_state;
    logic         unused_bits;

    assign running     = (state != ST_IDLE) && (state != ST_UP);
    assign accept      = start && !running;
    assign settled     = ({{(32-ECW){1'b0}}, elapsed} >= 32'(SETTLE_TICKS));
    assign stall_state = (dbg_word0[5:0] == RCVRLOCK_CODE);
    assign unused_bits = ^{dbg_word0[31:6], poll_cnt};

    plw_tick_cnt #(.LIMIT(DEADLINE_TICKS), .CW(ECW)) u_elapsed (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .tick    (ms_tick && running),
        .count   (elapsed),
        .reached (deadline_hit)
    );

    plw_tick_cnt #(.LIMIT(POLL_TICKS), .CW(PCW)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_WAIT),
        .tick    (ms_tick),
        .count   (poll_cnt),
        .reached (poll_hit)
    );

    plw_phy_port u_port (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .op        (op),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .done      (done),
        .rdata     (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            go        <= 1'b0;
            op        <= '0;
            link_up   <= 1'b0;
            timeout   <= 1'b0;
            recov_evt <= 1'b0;
        end else begin
            go        <= 1'b0;
            recov_evt <= 1'b0;
            case (state)
                ST_IDLE, ST_UP: begin
                    if (start) begin
                        state   <= ST_WAIT;
                        link_up <= 1'b0;
                        timeout <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (deadline_hit) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (poll_hit) begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (link_ok(dbg_word1)) begin
                        link_up <= 1'b1;
                        state   <= ST_UP;
                    end else if (settled && stall_state) begin
                        go    <= 1'b1;
                        op    <= mk_op(1'b0, RXSTAT_ADDR, 16'h0000);
                        state <= ST_PROBE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_PROBE: begin
                    if (done) begin
                        if (rd_val[0]) begin
                            state <= ST_WAIT;
                        end else begin
                            go    <= 1'b1;
                            op    <= mk_op(1'b0, OVRD_ADDR, 16'h0000);
                            state <= ST_OVR_RD1;
                        end
                    end
                end
                ST_OVR_RD1: begin
                    if (done) begin
                        go    <= 1'b1;
                        op    <= mk_op(1'b1, OVRD_ADDR, rd_val | OVRD_MASK);
                        state <= ST_OVR_WR1;
                    end
                end
                ST_OVR_WR1: begin
                    if (done) begin
                        go    <= 1'b1;
                        op    <= mk_op(1'b0, OVRD_ADDR, 16'h0000);
                        state <= ST_OVR_RD2;
                    end
                end
                ST_OVR_RD2: begin
                    if (done) begin
                        go    <= 1'b1;
                        op    <= mk_op(1'b1, OVRD_ADDR, rd_val & ~OVRD_MASK);
                        state <= ST_OVR_WR2;
                    end
                end
                ST_OVR_WR2: begin
                    if (done) begin
                        recov_evt <= 1'b1;
                        state     <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/plw_checker.sv
module plw_checker
    import plw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        ms_tick,
    input logic [31:0] dbg_word0,
    input logic [31:0] dbg_word1,
    input logic        phy_req,
    input logic        phy_we,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic        phy_ack,
    input logic [15:0] phy_rdata,
    input logic        link_up,
    input logic        timeout,
    input logic        recov_evt
);
    logic unused_in;
    assign unused_in = ^{start, ms_tick, dbg_word0, phy_rdata};

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_we)
                                   && $stable(phy_addr) && $stable(phy_wdata)));

    p_evt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        recov_evt |=> !recov_evt);

    p_evt_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(recov_evt) |-> $past(phy_ack && phy_we && (phy_addr == OVRD_ADDR), 2));

    p_link_rule_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(link_ok(dbg_word1)));

    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(link_up && timeout));

    p_addr_r6: assert property (@(posedge clk) disable iff (rst)
        phy_req |-> ((phy_addr == RXSTAT_ADDR && !phy_we) || phy_addr == OVRD_ADDR));
endmodule

bind pcie_link_watch plw_checker u_chk (.*);

// File: tb/pcie_link_watch_tb.sv
module pcie_link_watch_tb;
    localparam int POLL = 2;
    localparam int SETTLE = 3;
    localparam int DEADLINE = 20;
    localparam int DIV = 8;
    localparam int ACK_DLY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic [31:0] dbg_word0 = '0;
    logic [31:0] dbg_word1 = '0;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        link_up, timeout, recov_evt;

    int tests = 0;
    int fails = 0;
    int tick_count = 0;
    bit clr_req = 1'b0;
    logic [15:0] rx_val = 16'h0001;
    logic [15:0] ovr_reg = 16'h0000;
    int log_n = 0;
    logic        log_we [16];
    logic [15:0] log_addr [16];
    logic [15:0] log_data [16];
    int first_req_tick = -1;
    int drop_errs = 0;
    int evt_run = 0;
    int evt_max = 0;
    int evt_cnt = 0;

    always #4 clk = ~clk;

    pcie_link_watch #(.POLL_TICKS(POLL), .SETTLE_TICKS(SETTLE),
                      .DEADLINE_TICKS(DEADLINE), .RCVRLOCK_CODE(6'h0D)) u_dut (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .dbg_word0(dbg_word0), .dbg_word1(dbg_word1),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .link_up(link_up), .timeout(timeout), .recov_evt(recov_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // time base
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (clr_req) begin
                clr_req = 1'b0;
                div = 0;
                tick_count = 0;
                ms_tick = 1'b0;
            end else if (div == DIV - 1) begin
                div = 0;
                ms_tick = 1'b1;
                tick_count++;
            end else begin
                div++;
                ms_tick = 1'b0;
            end
        end
    end

    // PHY register-access model with delayed acknowledge
    initial begin
        int cnt = 0;
        bit prev_req = 1'b0;
        bit acked = 1'b0;
        forever begin
            @(negedge clk);
            if (prev_req && !phy_req && !acked) drop_errs++;
            if (phy_req && !prev_req) begin
                acked = 1'b0;
                if (first_req_tick < 0) first_req_tick = tick_count;
            end
            prev_req = phy_req;
            if (phy_ack) begin
                phy_ack = 1'b0;
            end else if (phy_req && !acked) begin
                if (cnt == ACK_DLY) begin
                    cnt = 0;
                    acked = 1'b1;
                    phy_ack = 1'b1;
                    phy_rdata = (phy_addr == 16'h100D) ? rx_val : ovr_reg;
                    if (phy_we && phy_addr == 16'h1005) ovr_reg = phy_wdata;
                    if (log_n < 16) begin
                        log_we[log_n]   = phy_we;
                        log_addr[log_n] = phy_addr;
                        log_data[log_n] = phy_we ? phy_wdata : phy_rdata;
                    end
                    log_n++;
                end else begin
                    cnt++;
                end
            end
            if (recov_evt) begin
                evt_run++;
                if (evt_run > evt_max) evt_max = evt_run;
                if (evt_run == 1) evt_cnt++;
            end else begin
                evt_run = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic do_start();
        log_n = 0;
        first_req_tick = -1;
        evt_cnt = 0;
        evt_max = 0;
        clr_req = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int max_cycles);
        for (int i = 0; i < max_cycles; i++) begin
            if (link_up || timeout) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!link_up && !timeout && !recov_evt && !phy_req, "R1 reset",
            {link_up, timeout, recov_evt, phy_req}, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(!link_up && !timeout && !phy_req, "R1 idle after reset",
            {link_up, timeout, phy_req}, 0);

        // R2/R3/R4/R5: flag sweep over background patterns, LTSSM not stalled
        for (int bg = 0; bg < 3; bg++) begin
            for (int combo = 0; combo < 4; combo++) begin
                logic [31:0] base;
                bit b4, b29, exp_up;
                base = (bg == 0) ? 32'h0 : (bg == 1) ? 32'hFFFF_FFFF : 32'hA5A5_5A5A;
                b4 = combo[0];
                b29 = combo[1];
                exp_up = b4 && !b29;
                dbg_word0 = 32'h0000_0011;
                dbg_word1 = (base & ~32'h2000_0010) | ({31'b0, b4} << 4) | ({31'b0, b29} << 29);
                do_start();
                chk(!timeout && !link_up, "R4 start clears flags", {link_up, timeout}, 0);
                wait_end(DEADLINE * DIV + 100);
                chk(link_up == exp_up, "R2 link decision", link_up, exp_up);
                chk(timeout == !exp_up, "R4 timeout when no link", timeout, !exp_up);
                if (exp_up)
                    chk(tick_count == POLL, "R3 first poll tick", tick_count, POLL);
                else
                    chk(tick_count == DEADLINE, "R4 deadline tick", tick_count, DEADLINE);
                chk(log_n == 0, "R5 no PHY access off stall state", log_n, 0);
                dbg_word1 = exp_up ? 32'h2000_0000 : 32'h0000_0010;
                repeat (40) @(negedge clk);
                chk(link_up == exp_up && timeout == !exp_up, "R2 R4 outputs held",
                    {link_up, timeout}, {exp_up, !exp_up});
            end
        end

        // R5: LTSSM at a neighbouring code
        dbg_word0 = 32'h0000_000C;
        dbg_word1 = 32'h0;
        do_start();
        wait_end(DEADLINE * DIV + 100);
        chk(timeout && log_n == 0, "R5 wrong LTSSM code no probe", log_n, 0);

        // R5/R6: stalled LTSSM, receiver valid
        dbg_word0 = 32'hFFFF_FFCD;
        rx_val = 16'h0001;
        do_start();
        wait_end(DEADLINE * DIV + 200);
        chk(timeout, "R4 timeout with valid receiver", timeout, 1);
        chk(first_req_tick == 4, "R5 first probe after settle", first_req_tick, 4);
        chk(log_n >= 1, "R6 probe issued", log_n, 1);
        begin
            int bad = 0;
            for (int i = 0; i < log_n && i < 16; i++)
                if (log_we[i] || log_addr[i] != 16'h100D) bad++;
            chk(bad == 0, "R6 only receiver status reads", bad, 0);
        end
        chk(evt_cnt == 0, "R8 no event without override", evt_cnt, 0);

        // R7/R8/R9: stalled LTSSM, receiver invalid
        rx_val = 16'hFFFE;
        ovr_reg = 16'h1234;
        do_start();
        for (int i = 0; i < 2000; i++) begin
            if (evt_cnt != 0) break;
            @(negedge clk);
        end
        chk(evt_cnt == 1, "R8 recovery event seen", evt_cnt, 1);
        chk(log_n >= 5, "R7 access count", log_n, 5);
        chk(!log_we[0] && log_addr[0] == 16'h100D, "R7 step0 probe", log_addr[0], 16'h100D);
        chk(!log_we[1] && log_addr[1] == 16'h1005 && log_data[1] == 16'h1234,
            "R7 step1 read", log_data[1], 16'h1234);
        chk(log_we[2] && log_addr[2] == 16'h1005 && log_data[2] == 16'h123C,
            "R7 step2 set", log_data[2], 16'h123C);
        chk(!log_we[3] && log_addr[3] == 16'h1005 && log_data[3] == 16'h123C,
            "R7 step3 read", log_data[3], 16'h123C);
        chk(log_we[4] && log_addr[4] == 16'h1005 && log_data[4] == 16'h1214,
            "R7 step4 clear", log_data[4], 16'h1214);
        dbg_word1 = 32'h0000_0010;
        wait_end(DEADLINE * DIV + 200);
        chk(link_up, "R2 link after recovery", link_up, 1);
        chk(evt_max == 1, "R8 event one cycle wide", evt_max, 1);
        chk(drop_errs == 0, "R9 request held until ack", drop_errs, 0);
        chk(!phy_req, "R9 no request after link up", phy_req, 0);

        summary();
    end
endmodule